// File: doc/BRIEF.md
# Cascadable Presettable Counter Stage

This block is a four-bit synchronous counter slice. It is meant to be chained into wider counters. Loading and counting both happen on the rising clock edge. An active-low parallel-load input captures a four-bit preset word. An active-low master clear forces the count to zero and overrides every other input.

Two active-high count enables must both be high for the slice to advance. Only one of them, the carry enable, also gates the terminal-count output. To build a counter of N slices, connect one shared advance enable to every slice. Feed each slice's terminal-count output into the carry enable of the next, more significant slice. The carry then ripples through the combinational terminal-count gates, and all slices step on the same clock edge.

Two parameters set the variant:
- The clear can act at once (asynchronous) or only at a rising edge (synchronous).
- The count sequence can be binary (0 to 15) or decade (0 to 9). In decade mode the slice returns to zero after one enabled step from any out-of-range value (10 to 15). Such a value can come from a load or from power-up.

Top module: `cnt_stage`

## Requirements
- R1: When `mr_n` is low at a rising clock edge, `q` is 0 after that edge, whatever the levels of `ld_n`, `cen_p` and `cen_t`.
- R2: With `ASYNC_CLR=1`, `q` becomes 0 as soon as `mr_n` goes low, with no clock edge needed.
- R3: With `ASYNC_CLR=0`, a low `mr_n` leaves `q` unchanged until the next rising clock edge.
- R4: When `mr_n` is high and `ld_n` is low at a rising edge, `q` takes the value of `din` and the count enables have no effect.
- R5: When `mr_n` and `ld_n` are high, `q` rises by one at a rising edge only if `cen_p` and `cen_t` are both high. Otherwise `q` holds.
- R6: An enabled step from the top value wraps to 0. The top value is 15 with `DECADE=0` and 9 with `DECADE=1`.
- R7: With `DECADE=1`, an enabled step from any value from 10 to 15 gives 0.
- R8: `tco` is high exactly when `cen_t` is high and `q` equals the top value. It does not depend on `cen_p` or on the clock.
- R9: Three slices chained `tco`→`cen_t` with a shared `cen_p` count as one 12-bit binary counter. This holds for both clear variants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| mr_n | input | 1 | Master clear, active low; highest priority |
| ld_n | input | 1 | Parallel load enable, active low |
| din | input | 4 | Preset word captured on load |
| cen_p | input | 1 | Advance enable shared by all slices |
| cen_t | input | 1 | Carry enable; also gates `tco` |
| q | output | 4 | Current count |
| tco | output | 1 | Terminal-count flag for the next slice |

## Verification
The bench drives two three-slice chains, one with each clear variant, and two decade slices, all from the same inputs.

Targeted corner cases:
- **Clear timing.** A clear is dropped mid-cycle. The immediate variant must read zero before the next edge and the synchronous variant must not. A design that swapped the two shows a mismatch in that window.
- **Wrap and carry.** A preset just below the all-ones value makes every slice wrap on the same edge. A design whose carry waits on `cen_p`, or whose slices see the carry one cycle late, would show the upper nibbles off by one.
- **Decade recovery.** The decade slices are loaded with 10 to 15 and then stepped. A plain incrementer would walk through the out-of-range codes instead of returning to 0.
- **Carry independence.** `tco` is checked with `cen_p` low while the count sits at its top value.

A long free-running stretch and a random mix of clears, loads and enables are compared against a reference model at every edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic mr_n;
        logic ld_n;
        logic en_p;
        logic en_t;
    } cnt_ctl_t;

    localparam int unsigned DEC_TOP = 9;

    function automatic int unsigned top_value(int unsigned width, bit decade);
        return decade ? DEC_TOP : ((32'd1 << width) - 32'd1);
    endfunction

    function automatic int unsigned wrap_step(int unsigned cur, int unsigned top);
        return (cur >= top) ? 32'd0 : cur + 32'd1;
    endfunction

endpackage

// File: rtl/cnt_op_sel.sv
module cnt_op_sel
    import cnt_pkg::*;
(
    input  cnt_ctl_t ctl,
    output cnt_op_e  op
);

    always_comb begin
        if (!ctl.mr_n)
            op = OP_CLEAR;
        else if (!ctl.ld_n)
            op = OP_LOAD;
        else if (ctl.en_p && ctl.en_t)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/cnt_next.sv
module cnt_next
    import cnt_pkg::*;
#(
    parameter int unsigned W   = 4,
    parameter int unsigned TOP = 15
) (
    input  cnt_op_e        op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   nxt
);

    logic [W-1:0] stepped;

    assign stepped = W'(wrap_step(32'(cur), TOP));

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_STEP:  nxt = stepped;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_store.sv
module cnt_store #(
    parameter int unsigned W         = 4,
    parameter bit          ASYNC_CLR = 1'b1
) (
    input  logic         clk,
    input  logic         mr_n,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q
);

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge mr_n) begin
                if (!mr_n)
                    q <= '0;
                else
                    q <= nxt;
            end

            AST_ASYNC_ZERO: assert property (@(posedge clk) !mr_n |-> q == '0); // R2
        end else begin : g_sync
            always_ff @(posedge clk) begin
                q <= nxt;
            end
        end
    endgenerate

endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
    parameter int unsigned W   = 4,
    parameter int unsigned TOP = 15
) (
    input  logic [W-1:0] q,
    input  logic         en_t,
    output logic         tc
);

    localparam logic [W-1:0] TOP_V = W'(TOP);

    assign tc = en_t && (q == TOP_V);

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int unsigned W         = 4,
    parameter bit          DECADE    = 1'b0,
    parameter bit          ASYNC_CLR = 1'b1
) (
    input  logic         clk,
    input  logic         mr_n,
    input  logic         ld_n,
    input  logic [W-1:0] din,
    input  logic         cen_p,
    input  logic         cen_t,
    output logic [W-1:0] q,
    output logic         tco
);

    localparam int unsigned   TOP   = top_value(W, DECADE);
    localparam logic [W-1:0]  TOP_V = W'(TOP);

    cnt_ctl_t     ctl;
    cnt_op_e      op;
    logic [W-1:0] nxt;

    assign ctl = '{mr_n: mr_n, ld_n: ld_n, en_p: cen_p, en_t: cen_t};

    cnt_op_sel u_sel (
        .ctl (ctl),
        .op  (op)
    );

    cnt_next #(.W(W), .TOP(TOP)) u_next (
        .op  (op),
        .cur (q),
        .din (din),
        .nxt (nxt)
    );

    cnt_store #(.W(W), .ASYNC_CLR(ASYNC_CLR)) u_store (
        .clk  (clk),
        .mr_n (mr_n),
        .nxt  (nxt),
        .q    (q)
    );

    cnt_tc #(.W(W), .TOP(TOP)) u_tc (
        .q    (q),
        .en_t (cen_t),
        .tc   (tco)
    );

    AST_CLEAR_WINS: assert property (@(posedge clk) !mr_n |=> q == '0); // R1

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!mr_n)
        !ld_n |=> q == $past(din)); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!mr_n)
        (ld_n && !(cen_p && cen_t)) |=> $stable(q)); // R5

    AST_INC_ONE: assert property (@(posedge clk) disable iff (!mr_n)
        (ld_n && cen_p && cen_t && q < TOP_V) |=> q == $past(q) + W'(1)); // R5

    AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!mr_n)
        (ld_n && cen_p && cen_t && q == TOP_V) |=> q == '0); // R6

    generate
        if (DECADE) begin : g_dec_chk
            AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (!mr_n)
                (ld_n && cen_p && cen_t && q > TOP_V) |=> q == '0); // R7
        end
    endgenerate

    AST_TC_QUALIFIED: assert property (@(posedge clk) disable iff (!mr_n)
        tco |-> (cen_t && q == TOP_V)); // R8

endmodule

// File: tb/cnt_stage_test.sv
module cnt_stage_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        mr_n, ld_n, cen_p, cen_t;
    logic [11:0] din12;
    logic [3:0]  ddin;
    logic [11:0] qa, qb;
    logic [2:0]  tca, tcb;
    logic [3:0]  dqa, dqs;
    logic        dtca, dtcs;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    int ra, rb, xa, xs;

    always #(PERIOD/2) clk = ~clk;

    // chain A: immediate clear
    cnt_stage #(.ASYNC_CLR(1'b1)) uut (.clk(clk), .mr_n(mr_n), .ld_n(ld_n), .din(din12[3:0]),
        .cen_p(cen_p), .cen_t(cen_t), .q(qa[3:0]), .tco(tca[0]));
    cnt_stage #(.ASYNC_CLR(1'b1)) a1 (.clk(clk), .mr_n(mr_n), .ld_n(ld_n), .din(din12[7:4]),
        .cen_p(cen_p), .cen_t(tca[0]), .q(qa[7:4]), .tco(tca[1]));
    cnt_stage #(.ASYNC_CLR(1'b1)) a2 (.clk(clk), .mr_n(mr_n), .ld_n(ld_n), .din(din12[11:8]),
        .cen_p(cen_p), .cen_t(tca[1]), .q(qa[11:8]), .tco(tca[2]));
    // chain B: clocked clear
    cnt_stage #(.ASYNC_CLR(1'b0)) b0 (.clk(clk), .mr_n(mr_n), .ld_n(ld_n), .din(din12[3:0]),
        .cen_p(cen_p), .cen_t(cen_t), .q(qb[3:0]), .tco(tcb[0]));
    cnt_stage #(.ASYNC_CLR(1'b0)) b1 (.clk(clk), .mr_n(mr_n), .ld_n(ld_n), .din(din12[7:4]),
        .cen_p(cen_p), .cen_t(tcb[0]), .q(qb[7:4]), .tco(tcb[1]));
    cnt_stage #(.ASYNC_CLR(1'b0)) b2 (.clk(clk), .mr_n(mr_n), .ld_n(ld_n), .din(din12[11:8]),
        .cen_p(cen_p), .cen_t(tcb[1]), .q(qb[11:8]), .tco(tcb[2]));
    // decade slices
    cnt_stage #(.DECADE(1'b1), .ASYNC_CLR(1'b1)) da (.clk(clk), .mr_n(mr_n), .ld_n(ld_n),
        .din(ddin), .cen_p(cen_p), .cen_t(cen_t), .q(dqa), .tco(dtca));
    cnt_stage #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) ds (.clk(clk), .mr_n(mr_n), .ld_n(ld_n),
        .din(ddin), .cen_p(cen_p), .cen_t(cen_t), .q(dqs), .tco(dtcs));

    function automatic int bin_next(int cur);
        if (!mr_n) return 0;
        if (!ld_n) return int'(din12);
        if (cen_p && cen_t) return (cur + 1) % 4096;
        return cur;
    endfunction

    function automatic int dec_next(int cur);
        if (!mr_n) return 0;
        if (!ld_n) return int'(ddin);
        if (cen_p && cen_t) return (cur >= 9) ? 0 : cur + 1;
        return cur;
    endfunction

    function automatic logic [2:0] chain_tc(int v);
        logic t0, t1, t2;
        t0 = cen_t && ((v & 15) == 15);
        t1 = t0 && (((v >> 4) & 15) == 15);
        t2 = t1 && (((v >> 8) & 15) == 15);
        return {t2, t1, t0};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag, string dtag);
        chk(tag, 32'(qa), 32'(ra));
        chk(tag, 32'(qb), 32'(rb));
        chk(dtag, 32'(dqa), 32'(xa));
        chk(dtag, 32'(dqs), 32'(xs));
        chk("R8 chain A tco", 32'(tca), 32'(chain_tc(ra)));
        chk("R8 chain B tco", 32'(tcb), 32'(chain_tc(rb)));
        chk("R8 decade tco", 32'({dtca, dtcs}),
            32'({cen_t && xa == 9, cen_t && xs == 9}));
    endtask

    task automatic tick(string tag, string dtag);
        @(posedge clk);
        ra = bin_next(ra);
        rb = bin_next(rb);
        xa = dec_next(xa);
        xs = dec_next(xs);
        #1;
        check_all(tag, dtag);
    endtask

    task automatic drive(logic m, logic l, logic p, logic t, logic [11:0] d, logic [3:0] dd);
        mr_n = m; ld_n = l; cen_p = p; cen_t = t; din12 = d; ddin = dd;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        ra = 0; rb = 0; xa = 0; xs = 0;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 4'h0);
        #1 mr_n = 1'b0;

        // R1: clear wins over load and enables
        drive(1'b0, 1'b0, 1'b1, 1'b1, 12'hABC, 4'h5);
        tick("R1", "R1");

        // R4: load preset
        drive(1'b1, 1'b0, 1'b1, 1'b1, 12'hFFD, 4'h7);
        tick("R4", "R4");
        // R5 / R6 / R9: run across all-ones wrap
        drive(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 4'h0);
        for (int i = 0; i < 4; i++) tick("R6", "R6");

        // R8: tco with cen_p low at top value
        drive(1'b1, 1'b0, 1'b1, 1'b1, 12'hFFF, 4'h9);
        tick("R4", "R4");
        drive(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 4'h0);
        tick("R5 hold", "R5 hold");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 12'h000, 4'h0);
        tick("R5 hold", "R5 hold");
        drive(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 4'h0);
        tick("R6", "R6");

        // R7: decade recovery from each illegal value
        for (int v = 10; v < 16; v++) begin
            drive(1'b1, 1'b0, 1'b1, 1'b1, 12'h123, 4'(v));
            tick("R4", "R4");
            drive(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 4'h0);
            tick("R5", "R7");
        end

        // R2 / R3: mid-cycle clear
        drive(1'b1, 1'b0, 1'b1, 1'b1, 12'h5A7, 4'h6);
        tick("R4", "R4");
        mr_n = 1'b0;
        #2;
        chk("R2 immediate clear chain", 32'(qa), 32'd0);
        chk("R2 immediate clear decade", 32'(dqa), 32'd0);
        chk("R3 clocked clear chain waits", 32'(qb), 32'(rb));
        chk("R3 clocked clear decade waits", 32'(dqs), 32'(xs));
        ra = 0; xa = 0;
        tick("R1", "R1");

        // R9: full 12-bit sequence plus wrap
        drive(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 4'h0);
        for (int i = 0; i < 4100; i++) tick("R9", "R6");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            mr_n  = ($urandom % 64) != 0;
            ld_n  = ($urandom % 16) != 0;
            cen_p = ($urandom % 8) != 0;
            cen_t = ($urandom % 8) != 0;
            din12 = ($urandom % 2) ? (12'hFF0 | 12'($urandom % 16)) : 12'($urandom % 4096);
            ddin  = 4'($urandom % 16);
            tick("R9", "R7");
        end

        done = 1;
        finish_run();
    end

endmodule